// File: doc/BRIEF.md
# Dual-Thread Core Sleep-State Controller

This block manages the low-power state of one processor core that runs two hardware threads. Each thread may ask to sleep at a chosen depth. A request carries a tag that says how it was issued: a halt, a monitor-wait, or an I/O read of a power-level register. The core as a whole settles at the shallowest depth that any thread holds. Interrupts and writes to a watched address bring threads back to running.

In the shallow states the core only stops issuing work from the sleeping threads. In the two deep states it runs an ordered sequence of handshakes with external units:

- Entry to C3 flushes the private caches and then stops the core clocks.
- Entry to C6 also saves architectural state before the clocks stop, and then cuts power.
- Exit runs the same steps in reverse.

A wake event that arrives while an entry sequence is running is held. The entry completes, and the exit sequence then begins at once.

Top module: `coreSleepCtl`

## Requirements
- R1: After reset both threads run, the core state is C0, busy is low, and every handshake request output is low.
- R2: State codes are C0=0, C1=1, C1E=2, C3=3, C6=4. When no sequence is running, the core state equals the lowest code held by the two threads, so any running thread forces C0.
- R3: The method codes are halt=0, monitor-wait=1, I/O read=2; code 3 is reserved. A request is taken only from a running thread, and only in these cases:
  - halt with level C1 or C1E;
  - monitor-wait with a level from C1 to C6;
  - I/O read with level C3 or C6.
  Every other request is ignored.
- R4: In C1, C1E or C3, an interrupt wakes only the thread it targets. A monitored-address hit wakes only the sleeping threads that entered by monitor-wait.
- R5: In C6, any wake event for either thread wakes both threads.
- R6: C3 entry raises flushReq and waits for flushDone. It then raises clkStopReq and waits for clkStopAck. The core reports C3 only after that, and busy stays high throughout.
- R7: C6 entry runs in this order:
  1. flush;
  2. save (saveReq/saveDone);
  3. clock stop;
  4. power off (pwrOffReq/pwrOffAck).
  C6 exit runs in this order:
  1. drop pwrOffReq and wait for the ack to fall;
  2. drop clkStopReq and wait for the ack to fall;
  3. restore (restoreReq/restoreDone).
- R8: A snoop is acknowledged on snoopAck one cycle later when the core is not sequencing and not in C3 or C6. In the deep states and during sequences, a snoop is neither acknowledged nor wakes anything.
- R9: A wake event during an entry sequence is held. The entry finishes (clocks stop) and exit follows at once, waking the held threads.
- R10: No thread runs while the restore step of a C6 exit is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 2 | Per-thread sleep request strobe |
| reqMethod | input | 4 | Per-thread method code, thread t at bits [2t+1:2t] |
| reqLevel | input | 6 | Per-thread requested state code, thread t at bits [3t+2:3t] |
| irq | input | 2 | Per-thread interrupt |
| monHit | input | 1 | Write seen to the monitored address |
| snoop | input | 1 | Snoop event |
| flushReq | output | 1 | Flush private caches request |
| flushDone | input | 1 | Flush complete pulse |
| saveReq | output | 1 | Save architectural state request |
| saveDone | input | 1 | Save complete pulse |
| clkStopReq | output | 1 | Hold core clocks stopped (level) |
| clkStopAck | input | 1 | Clocks stopped (level, follows request) |
| pwrOffReq | output | 1 | Hold core power off (level) |
| pwrOffAck | input | 1 | Power removed (level, follows request) |
| restoreReq | output | 1 | Restore architectural state request |
| restoreDone | input | 1 | Restore complete pulse |
| coreState | output | 3 | Resolved core state code |
| threadRun | output | 2 | Per-thread running flag |
| busy | output | 1 | Entry or exit sequence in progress |
| snoopAck | output | 1 | Snoop serviced |

## Verification
The risky overlap is an interrupt that arrives in the same cycle as an open entry handshake. The bench stretches the flush responder's latency and fires the interrupt one cycle after the sequence starts. It then judges the result by three facts at the ports: the clock-stop request rose and later fell, only the targeted thread came back, and the core returned to C0. Randomized shallow traffic mixes requests, interrupts, monitored-address hits and snoops in the same cycles. A bench model of each thread's state predicts the core state, the run flags and the snoop acks.

// File: rtl/csleep_pkg.sv
`timescale 1ns/1ps
package csleep_pkg;
  localparam int NTHR  = 2;
  localparam int CST_W = 3;
  localparam int MTH_W = 2;

  localparam logic [CST_W-1:0] ST_C0  = 3'd0;
  localparam logic [CST_W-1:0] ST_C1  = 3'd1;
  localparam logic [CST_W-1:0] ST_C1E = 3'd2;
  localparam logic [CST_W-1:0] ST_C3  = 3'd3;
  localparam logic [CST_W-1:0] ST_C6  = 3'd4;

  localparam logic [MTH_W-1:0] M_HALT  = 2'd0;
  localparam logic [MTH_W-1:0] M_MWAIT = 2'd1;
  localparam logic [MTH_W-1:0] M_IORD  = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_FLUSH, S_SAVE, S_STOP, S_PWROFF,
    S_DEEP, S_PWRON, S_START, S_RESTORE
  } seq_e;

  typedef struct packed {
    logic [NTHR-1:0] wake;
    logic            block;
  } strobe_t;
endpackage

// File: rtl/sleepThreads.sv
`timescale 1ns/1ps
module sleepThreads
  import csleep_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NTHR-1:0]         reqValid,
  input  logic [NTHR*MTH_W-1:0]   reqMethod,
  input  logic [NTHR*CST_W-1:0]   reqLevel,
  input  strobe_t                 stb,
  output logic [NTHR-1:0]         thrRun,
  output logic [NTHR-1:0]         thrMwait,
  output logic [CST_W-1:0]        target
);
  logic [NTHR*CST_W-1:0] thrFlat;

  function automatic logic reqOk(input logic [MTH_W-1:0] m, input logic [CST_W-1:0] l);
    case (m)
      M_HALT:  return (l == ST_C1) || (l == ST_C1E);
      M_MWAIT: return (l >= ST_C1) && (l <= ST_C6);
      M_IORD:  return (l == ST_C3) || (l == ST_C6);
      default: return 1'b0;
    endcase
  endfunction

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic [CST_W-1:0] st;
    logic             mw;
    logic [MTH_W-1:0] m;
    logic [CST_W-1:0] l;
    assign m = reqMethod[t*MTH_W +: MTH_W];
    assign l = reqLevel[t*CST_W +: CST_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        st <= ST_C0;
        mw <= 1'b0;
      end else if (stb.wake[t] && st != ST_C0) begin
        st <= ST_C0;
      end else if (!stb.block && reqValid[t] && st == ST_C0 && reqOk(m, l)) begin
        st <= l;
        mw <= (m == M_MWAIT);
      end
    end

    assign thrRun[t]                  = (st == ST_C0);
    assign thrMwait[t]                = mw;
    assign thrFlat[t*CST_W +: CST_W]  = st;
  end

  always_comb begin
    target = '1;
    for (int i = 0; i < NTHR; i++)
      if (thrFlat[i*CST_W +: CST_W] < target) target = thrFlat[i*CST_W +: CST_W];
  end
endmodule

// File: rtl/sleepSeq.sv
`timescale 1ns/1ps
module sleepSeq
  import csleep_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NTHR-1:0]   irq,
  input  logic              monHit,
  input  logic              snoop,
  input  logic [NTHR-1:0]   thrRun,
  input  logic [NTHR-1:0]   thrMwait,
  input  logic [CST_W-1:0]  target,
  input  logic              flushDone,
  input  logic              saveDone,
  input  logic              clkStopAck,
  input  logic              pwrOffAck,
  input  logic              restoreDone,
  output logic              flushReq,
  output logic              saveReq,
  output logic              clkStopReq,
  output logic              pwrOffReq,
  output logic              restoreReq,
  output strobe_t           stb,
  output logic [CST_W-1:0]  coreState,
  output logic              busy,
  output logic              snoopAck
);
  seq_e             fsm, nxt;
  logic [CST_W-1:0] deepTgt, settled;
  logic [NTHR-1:0]  pend, evtSleep, wake;
  logic             isC6;

  assign evtSleep = (irq | ({NTHR{monHit}} & thrMwait)) & ~thrRun;
  assign isC6     = (deepTgt == ST_C6);

  always_comb begin
    nxt = fsm;
    wake = '0;
    flushReq = 1'b0; saveReq = 1'b0; clkStopReq = 1'b0;
    pwrOffReq = 1'b0; restoreReq = 1'b0;
    case (fsm)
      S_IDLE: begin
        if (|evtSleep) wake = evtSleep;
        else if (target >= ST_C3) nxt = S_FLUSH;
      end
      S_FLUSH: begin
        flushReq = 1'b1;
        if (flushDone) nxt = isC6 ? S_SAVE : S_STOP;
      end
      S_SAVE: begin
        saveReq = 1'b1;
        if (saveDone) nxt = S_STOP;
      end
      S_STOP: begin
        clkStopReq = 1'b1;
        if (clkStopAck) nxt = isC6 ? S_PWROFF : S_DEEP;
      end
      S_PWROFF: begin
        clkStopReq = 1'b1; pwrOffReq = 1'b1;
        if (pwrOffAck) nxt = S_DEEP;
      end
      S_DEEP: begin
        clkStopReq = 1'b1; pwrOffReq = isC6;
        if (|(pend | evtSleep)) nxt = isC6 ? S_PWRON : S_START;
      end
      S_PWRON: begin
        clkStopReq = 1'b1;
        if (!pwrOffAck) nxt = S_START;
      end
      S_START: begin
        if (!clkStopAck) begin
          if (isC6) nxt = S_RESTORE;
          else begin
            wake = pend | evtSleep;
            nxt  = S_IDLE;
          end
        end
      end
      S_RESTORE: begin
        restoreReq = 1'b1;
        if (restoreDone) begin
          wake = '1;
          nxt  = S_IDLE;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsm      <= S_IDLE;
      deepTgt  <= ST_C0;
      pend     <= '0;
      settled  <= ST_C0;
      snoopAck <= 1'b0;
    end else begin
      fsm      <= nxt;
      settled  <= coreState;
      snoopAck <= snoop && (fsm == S_IDLE);
      if (fsm == S_IDLE) begin
        pend <= '0;
        if (nxt == S_FLUSH) deepTgt <= target;
      end else begin
        pend <= pend | evtSleep;
      end
    end
  end

  assign coreState = (fsm == S_DEEP) ? deepTgt :
                     (fsm == S_IDLE && target < ST_C3) ? target : settled;
  assign busy      = (fsm != S_IDLE) && (fsm != S_DEEP);
  assign stb.wake  = wake;
  assign stb.block = (fsm != S_IDLE);
endmodule

// File: rtl/coreSleepCtl.sv
`timescale 1ns/1ps
module coreSleepCtl
  import csleep_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NTHR-1:0]        reqValid,
  input  logic [NTHR*MTH_W-1:0]  reqMethod,
  input  logic [NTHR*CST_W-1:0]  reqLevel,
  input  logic [NTHR-1:0]        irq,
  input  logic                   monHit,
  input  logic                   snoop,
  output logic                   flushReq,
  input  logic                   flushDone,
  output logic                   saveReq,
  input  logic                   saveDone,
  output logic                   clkStopReq,
  input  logic                   clkStopAck,
  output logic                   pwrOffReq,
  input  logic                   pwrOffAck,
  output logic                   restoreReq,
  input  logic                   restoreDone,
  output logic [CST_W-1:0]       coreState,
  output logic [NTHR-1:0]        threadRun,
  output logic                   busy,
  output logic                   snoopAck
);
  strobe_t          stb;
  logic [NTHR-1:0]  thrMwait;
  logic [CST_W-1:0] target;

  sleepThreads u_thr (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMethod(reqMethod),
    .reqLevel(reqLevel), .stb(stb), .thrRun(threadRun), .thrMwait(thrMwait),
    .target(target)
  );

  sleepSeq u_seq (
    .clk(clk), .rstN(rstN), .irq(irq), .monHit(monHit), .snoop(snoop),
    .thrRun(threadRun), .thrMwait(thrMwait), .target(target),
    .flushDone(flushDone), .saveDone(saveDone), .clkStopAck(clkStopAck),
    .pwrOffAck(pwrOffAck), .restoreDone(restoreDone),
    .flushReq(flushReq), .saveReq(saveReq), .clkStopReq(clkStopReq),
    .pwrOffReq(pwrOffReq), .restoreReq(restoreReq), .stb(stb),
    .coreState(coreState), .busy(busy), .snoopAck(snoopAck)
  );
endmodule

// File: rtl/coreSleepChk.sv
`timescale 1ns/1ps
module coreSleepChk
  import csleep_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             flushReq,
  input logic             flushDone,
  input logic             saveReq,
  input logic             saveDone,
  input logic             clkStopReq,
  input logic             clkStopAck,
  input logic             pwrOffReq,
  input logic             restoreReq,
  input logic [NTHR-1:0]  threadRun,
  input logic [CST_W-1:0] coreState,
  input logic             snoop,
  input logic             snoopAck
);
  // R2
  run_forces_c0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|threadRun) |-> (coreState == ST_C0));

  // R6
  stop_after_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkStopReq) |-> $past(flushDone || saveDone));

  // R7
  save_after_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(saveReq) |-> $past(flushDone));

  // R7
  off_after_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwrOffReq) |-> $past(clkStopAck));

  // R7
  restore_powered_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(restoreReq) |-> (!clkStopReq && !pwrOffReq));

  // R10
  no_run_in_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    restoreReq |-> (threadRun == '0));

  // R8
  ack_needs_snoop_chk: assert property (@(posedge clk) disable iff (!rstN)
    snoopAck |-> $past(snoop));

  // R8
  no_ack_deep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coreState >= ST_C3) |-> !snoopAck);

  // R6
  one_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({flushReq, saveReq, restoreReq}));
endmodule

bind coreSleepCtl coreSleepChk u_chk (
  .clk(clk), .rstN(rstN), .flushReq(flushReq), .flushDone(flushDone),
  .saveReq(saveReq), .saveDone(saveDone), .clkStopReq(clkStopReq),
  .clkStopAck(clkStopAck), .pwrOffReq(pwrOffReq), .restoreReq(restoreReq),
  .threadRun(threadRun), .coreState(coreState), .snoop(snoop), .snoopAck(snoopAck)
);

// File: tb/tb_coreSleepCtl.sv
`timescale 1ns/1ps
module tb_coreSleepCtl;
  import csleep_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN;
  logic [1:0] reqValid, irq;
  logic [3:0] reqMethod;
  logic [5:0] reqLevel;
  logic monHit, snoop;
  logic flushReq, flushDone, saveReq, saveDone, clkStopReq, clkStopAck;
  logic pwrOffReq, pwrOffAck, restoreReq, restoreDone;
  logic [2:0] coreState;
  logic [1:0] threadRun;
  logic busy, snoopAck;

  coreSleepCtl dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMethod(reqMethod),
    .reqLevel(reqLevel), .irq(irq), .monHit(monHit), .snoop(snoop),
    .flushReq(flushReq), .flushDone(flushDone), .saveReq(saveReq), .saveDone(saveDone),
    .clkStopReq(clkStopReq), .clkStopAck(clkStopAck), .pwrOffReq(pwrOffReq),
    .pwrOffAck(pwrOffAck), .restoreReq(restoreReq), .restoreDone(restoreDone),
    .coreState(coreState), .threadRun(threadRun), .busy(busy), .snoopAck(snoopAck)
  );

  int nRun = 0, nFail = 0;
  int lat = 2;
  int fCnt, sCnt, rCnt;
  int cyc = 0;
  int tFlush, tSave, tStop, tOff, tOn, tStart, tRest;

  // handshake responders
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rstN) begin
      flushDone <= 0; saveDone <= 0; restoreDone <= 0;
      clkStopAck <= 0; pwrOffAck <= 0; fCnt <= 0; sCnt <= 0; rCnt <= 0;
    end else begin
      clkStopAck <= clkStopReq;
      pwrOffAck  <= pwrOffReq;
      flushDone <= 0; saveDone <= 0; restoreDone <= 0;
      if (flushReq && !flushDone) begin
        if (fCnt >= lat) begin flushDone <= 1; fCnt <= 0; end else fCnt <= fCnt + 1;
      end
      if (saveReq && !saveDone) begin
        if (sCnt >= lat) begin saveDone <= 1; sCnt <= 0; end else sCnt <= sCnt + 1;
      end
      if (restoreReq && !restoreDone) begin
        if (rCnt >= lat) begin restoreDone <= 1; rCnt <= 0; end else rCnt <= rCnt + 1;
      end
    end
  end

  // order stamps
  always @(negedge clk) begin
    if (flushReq   && tFlush < 0) tFlush = cyc;
    if (saveReq    && tSave  < 0) tSave  = cyc;
    if (clkStopReq && tStop  < 0) tStop  = cyc;
    if (pwrOffReq  && tOff   < 0) tOff   = cyc;
    if (tOff  >= 0 && !pwrOffReq  && tOn    < 0) tOn    = cyc;
    if (tStop >= 0 && !clkStopReq && tStart < 0) tStart = cyc;
    if (restoreReq && tRest  < 0) tRest  = cyc;
  end

  task automatic clrStamps();
    tFlush = -1; tSave = -1; tStop = -1; tOff = -1; tOn = -1; tStart = -1; tRest = -1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic req(input int t, input int m, input int l);
    reqValid[t] = 1'b1;
    reqMethod[t*2 +: 2] = m[1:0];
    reqLevel[t*3 +: 3] = l[2:0];
    tick();
    reqValid = '0;
  endtask

  task automatic pulseIrq(input logic [1:0] m);
    irq = m; tick(); irq = '0;
  endtask

  task automatic waitIdle(input string tag);
    int n = 0;
    tick();
    while (busy && n < 300) begin tick(); n++; end
    if (n >= 300) chk({tag, " sequence timeout"}, 1, 0);
  endtask

  function automatic logic expOk(input int m, input int l);
    case (m)
      0: return l == 1 || l == 2;
      1: return l >= 1 && l <= 4;
      2: return l == 3 || l == 4;
      default: return 1'b0;
    endcase
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    rstN = 0; reqValid = 0; reqMethod = 0; reqLevel = 0; irq = 0; monHit = 0; snoop = 0;
    clrStamps();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    tick();

    // R1 reset state
    chk("R1 coreState", coreState, 0);
    chk("R1 threadRun", threadRun, 2'b11);
    chk("R1 busy", busy, 0);
    chk("R1 requests", {flushReq, saveReq, clkStopReq, pwrOffReq, restoreReq}, 0);

    // R3 rejected requests
    req(0, 0, 3); chk("R3 halt C3 ignored", threadRun, 2'b11);
    req(0, 2, 2); chk("R3 io C1E ignored", threadRun, 2'b11);
    req(1, 3, 1); chk("R3 reserved method ignored", threadRun, 2'b11);
    req(1, 1, 0); chk("R3 mwait level0 ignored", threadRun, 2'b11);
    req(1, 1, 5); chk("R3 mwait level5 ignored", threadRun, 2'b11);

    // R2 minimum: C1E and C3 -> C1E
    req(0, 1, 2); req(1, 1, 3);
    chk("R2 min C1E/C3", coreState, 2);
    chk("R2 no deep entry", busy, 0);
    pulseIrq(2'b10);
    chk("R4 irq wakes one thread", threadRun, 2'b10);
    chk("R4 core back to C0", coreState, 0);
    pulseIrq(2'b01);

    // R3 sleeping thread request ignored, R8 shallow snoop
    req(0, 0, 1); req(1, 0, 2);
    chk("R2 min C1/C1E", coreState, 1);
    req(0, 1, 2);
    chk("R3 request from sleeping thread ignored", coreState, 1);
    snoop = 1; tick(); snoop = 0;
    chk("R8 snoop ack in C1", snoopAck, 1);
    chk("R8 snoop does not wake", threadRun, 2'b00);
    pulseIrq(2'b11);

    // R4 monitored-address hit
    req(0, 0, 1); req(1, 1, 1);
    monHit = 1; tick(); monHit = 0;
    chk("R4 monHit wakes mwait thread only", threadRun, 2'b10);
    pulseIrq(2'b01);

    // R6 C3 entry
    clrStamps();
    req(0, 2, 3);
    chk("R3 io C3 accepted", threadRun, 2'b10);
    req(1, 2, 3);
    waitIdle("R6");
    chk("R6 core in C3", coreState, 3);
    chk("R6 clocks stopped", clkStopReq, 1);
    chk("R6 flush before stop", (tFlush >= 0 && tStop > tFlush), 1);
    chk("R6 no save for C3", tSave, 32'hFFFF_FFFF);
    snoop = 1; tick(); snoop = 0;
    chk("R8 no snoop ack in C3", snoopAck, 0);
    chk("R8 snoop no wake in C3", {coreState, threadRun}, {3'd3, 2'b00});
    pulseIrq(2'b01);
    waitIdle("R4c3");
    chk("R4 C3 irq wakes one thread", threadRun, 2'b01);
    chk("R4 C3 exit core C0", coreState, 0);
    chk("R6 clocks restarted", clkStopReq, 0);
    pulseIrq(2'b10);
    chk("R4 direct wake second thread", threadRun, 2'b11);

    // R2 deep minimum: C3 + C6 -> C3
    clrStamps();
    req(0, 1, 3); req(1, 1, 4);
    waitIdle("R2deep");
    chk("R2 C3/C6 resolves C3", coreState, 3);
    chk("R2 C3/C6 no save", tSave, 32'hFFFF_FFFF);
    pulseIrq(2'b10);
    waitIdle("R4mix");
    chk("R4 wake C6-tagged thread only", threadRun, 2'b10);
    pulseIrq(2'b01);

    // R7 C6 entry and exit, R5
    clrStamps(); lat = 3;
    req(0, 1, 4); req(1, 2, 4);
    waitIdle("R7");
    chk("R7 core in C6", coreState, 4);
    chk("R7 entry order", (tFlush >= 0 && tSave > tFlush && tStop > tSave && tOff > tStop), 1);
    clrStamps();
    pulseIrq(2'b10);
    waitIdle("R5");
    chk("R5 both threads wake", threadRun, 2'b11);
    chk("R5 core C0", coreState, 0);
    chk("R7 exit order", (tOn >= 0 && tStart > tOn && tRest > tStart), 1);

    // R9 wake during entry
    clrStamps(); lat = 10;
    req(0, 2, 3); req(1, 1, 3);
    tick();
    chk("R9 flush started", flushReq, 1);
    pulseIrq(2'b01);
    begin
      int n = 0;
      while (!threadRun[0] && n < 300) begin tick(); n++; end
    end
    chk("R9 held wake delivered", threadRun, 2'b01);
    chk("R9 entry completed first", (tStop >= 0 && tStart > tStop), 1);
    chk("R9 core C0", coreState, 0);
    pulseIrq(2'b10);
    lat = 2;

    // R2/R4/R3/R8 randomized shallow traffic
    begin
      int st0 = 0, st1 = 0;
      logic mw0 = 0, mw1 = 0;
      void'($urandom(1234));
      for (int i = 0; i < 400; i++) begin
        int m0 = $urandom_range(0, 3), m1 = $urandom_range(0, 3);
        int l0 = $urandom_range(0, 2), l1 = $urandom_range(0, 2);
        logic v0 = ($urandom_range(0, 2) == 0), v1 = ($urandom_range(0, 2) == 0);
        logic i0 = ($urandom_range(0, 7) == 0), i1 = ($urandom_range(0, 7) == 0);
        logic mh = ($urandom_range(0, 7) == 0), sn = ($urandom_range(0, 3) == 0);
        int expMin;
        reqValid = {v1, v0}; reqMethod = {m1[1:0], m0[1:0]};
        reqLevel = {l1[2:0], l0[2:0]}; irq = {i1, i0}; monHit = mh; snoop = sn;
        if (st0 != 0 && (i0 || (mh && mw0))) st0 = 0;
        else if (st0 == 0 && v0 && expOk(m0, l0)) begin st0 = l0; mw0 = (m0 == 1); end
        if (st1 != 0 && (i1 || (mh && mw1))) st1 = 0;
        else if (st1 == 0 && v1 && expOk(m1, l1)) begin st1 = l1; mw1 = (m1 == 1); end
        tick();
        reqValid = 0; irq = 0; monHit = 0; snoop = 0;
        expMin = (st0 < st1) ? st0 : st1;
        chk("R2 random min state", coreState, expMin);
        chk("R4 random run flags", threadRun, {st1 == 0, st0 == 0});
        chk("R8 random snoop ack", snoopAck, sn);
      end
    end

    summary();
    $finish;
  end
endmodule